// File: doc/BRIEF.md
# Segment Base-Limit Translator

This block turns a segmented virtual address into a physical address. The virtual address has two parts: a segment number and an offset within that segment. A small table holds, for each segment, a base address, a limit and a valid flag. The segment number picks a table entry directly. The offset is checked against that entry's limit. If the check passes, the base is added to the offset to form the physical address. If it fails, the block reports a protection fault and gives no address.

Software, or a surrounding controller, fills the table through a write port. The write port sets the base, the limit and the valid flag of one segment per cycle. The translate port takes one request per cycle. It answers one cycle later with either an address or a fault.

Top module: `seg_xlate`

## Requirements
- R1: After reset, `rspValid` is low and every segment is invalid, so any request faults until its segment has been written.
- R2: A request accepted on a clock edge (`reqValid` high) produces `rspValid` high on exactly the next cycle. `rspValid` is low in every cycle that follows a cycle with no request.
- R3: The segment number `reqSeg` selects the table entry directly; entry k is used only for segment number k.
- R4: For a valid segment with `reqOff < limit`, the response has `rspFault` low and `rspAddr` equal to base + `reqOff`.
- R5: An offset greater than or equal to the segment's limit gives `rspFault` high; an offset equal to the limit faults.
- R6: A request to a segment whose valid flag is clear gives `rspFault` high. Writing a segment with `wrValid` low clears its valid flag.
- R7: If base + offset does not fit in `ADDR_W` bits, the response is a fault.
- R8: A table write takes effect for requests from the next cycle on. A request in the same cycle as a write to its segment uses the entry as it was before that write.
- R9: Whenever `rspFault` is high, `rspAddr` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write one table entry |
| wrSeg | input | SEG_W | Segment number being written |
| wrBase | input | ADDR_W | Base address to store |
| wrLimit | input | OFF_W+1 | Limit to store; offsets below it are allowed |
| wrValid | input | 1 | Valid flag to store |
| reqValid | input | 1 | Translate request strobe |
| reqSeg | input | SEG_W | Segment number of the request |
| reqOff | input | OFF_W | Offset of the request |
| rspValid | output | 1 | Response present, one cycle after the request |
| rspFault | output | 1 | Protection fault for the response |
| rspAddr | output | ADDR_W | Physical address, zero on a fault |

## Verification
Every response is due exactly one clock edge after its request. The bench reference model works out the expected response at the edge where the request is taken, using the table contents as they stand before any write on that same edge. It then applies the write. On the following falling edge it compares `rspValid`, `rspFault` and `rspAddr` with the model. This timing places table updates at the cycle after the write, and it holds for same-cycle write/request pairs too. Each cycle's expectation is labelled with the rule that decides it (limit, invalid, overflow, write timing), so a mismatch points to that rule.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  // Strobes passed from control to datapath each cycle.
  typedef struct packed {
    logic loadEntry;  // store wr* fields into the addressed entry
    logic takeReq;    // capture a translation result
  } xlateStrobes_t;
endpackage

// File: rtl/seg_xlate_ctrl.sv
module seg_xlate_ctrl
  import seg_xlate_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic          reqValid,
  output xlateStrobes_t strb,
  output logic          rspValid
);
  always_comb begin
    strb.loadEntry = wrEn;
    strb.takeReq   = reqValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) rspValid <= 1'b0;
    else       rspValid <= reqValid;
  end

  AST_RSP_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid); // R2
  AST_RSP_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid); // R2
endmodule

// File: rtl/seg_xlate_dp.sv
module seg_xlate_dp
  import seg_xlate_pkg::*;
#(
  parameter int NUM_SEG = 8,
  parameter int OFF_W   = 12,
  parameter int ADDR_W  = 16,
  localparam int SEG_W  = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1,
  localparam int LIM_W  = OFF_W + 1
)(
  input  logic              clk,
  input  logic              rstN,
  input  xlateStrobes_t     strb,
  input  logic [SEG_W-1:0]  wrSeg,
  input  logic [ADDR_W-1:0] wrBase,
  input  logic [LIM_W-1:0]  wrLimit,
  input  logic              wrValid,
  input  logic [SEG_W-1:0]  reqSeg,
  input  logic [OFF_W-1:0]  reqOff,
  output logic              rspFault,
  output logic [ADDR_W-1:0] rspAddr
);
  localparam int SUM_W = ADDR_W + 1;

  logic [ADDR_W-1:0] baseQ  [NUM_SEG];
  logic [LIM_W-1:0]  limitQ [NUM_SEG];
  logic [NUM_SEG-1:0] validQ;

  // One register set per table entry.
  for (genvar g = 0; g < NUM_SEG; g++) begin : gEntry
    always_ff @(posedge clk) begin
      if (!rstN) begin
        validQ[g] <= 1'b0;
        baseQ[g]  <= '0;
        limitQ[g] <= '0;
      end else if (strb.loadEntry && (int'(wrSeg) == g)) begin
        validQ[g] <= wrValid;
        baseQ[g]  <= wrBase;
        limitQ[g] <= wrLimit;
      end
    end
  end

  logic              segInRange, segOk, inLimit, overflow, faultNow;
  logic [ADDR_W-1:0] selBase;
  logic [LIM_W-1:0]  selLimit;
  logic [SUM_W-1:0]  sum;

  always_comb begin
    segInRange = int'(reqSeg) < NUM_SEG;
    selBase    = '0;
    selLimit   = '0;
    segOk      = 1'b0;
    if (segInRange) begin
      selBase  = baseQ[reqSeg];
      selLimit = limitQ[reqSeg];
      segOk    = validQ[reqSeg];
    end
    inLimit  = {1'b0, reqOff} < selLimit;
    sum      = {1'b0, selBase} + SUM_W'(reqOff);
    overflow = sum[ADDR_W];
    faultNow = !segOk || !inLimit || overflow;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspFault <= 1'b0;
      rspAddr  <= '0;
    end else if (strb.takeReq) begin
      rspFault <= faultNow;
      rspAddr  <= faultNow ? '0 : sum[ADDR_W-1:0];
    end
  end

  AST_INVALID_FAULTS: assert property (@(posedge clk) disable iff (!rstN)
    (strb.takeReq && !segOk) |=> rspFault); // R6
  AST_LIMIT_FAULTS: assert property (@(posedge clk) disable iff (!rstN)
    (strb.takeReq && ({1'b0, reqOff} >= selLimit)) |=> rspFault); // R5
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (strb.takeReq && overflow) |=> rspFault); // R7
  AST_FAULT_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    rspFault |-> (rspAddr == '0)); // R9
  AST_WRITE_NEXT: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadEntry && (int'(wrSeg) < NUM_SEG)) |=> (validQ[$past(wrSeg)] == $past(wrValid))); // R8
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int NUM_SEG = 8,
  parameter int OFF_W   = 12,
  parameter int ADDR_W  = 16,
  localparam int SEG_W  = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [SEG_W-1:0]  wrSeg,
  input  logic [ADDR_W-1:0] wrBase,
  input  logic [OFF_W:0]    wrLimit,
  input  logic              wrValid,
  input  logic              reqValid,
  input  logic [SEG_W-1:0]  reqSeg,
  input  logic [OFF_W-1:0]  reqOff,
  output logic              rspValid,
  output logic              rspFault,
  output logic [ADDR_W-1:0] rspAddr
);
  xlateStrobes_t strb;

  seg_xlate_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .reqValid(reqValid),
    .strb(strb), .rspValid(rspValid)
  );

  seg_xlate_dp #(.NUM_SEG(NUM_SEG), .OFF_W(OFF_W), .ADDR_W(ADDR_W)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .wrSeg(wrSeg), .wrBase(wrBase), .wrLimit(wrLimit), .wrValid(wrValid),
    .reqSeg(reqSeg), .reqOff(reqOff),
    .rspFault(rspFault), .rspAddr(rspAddr)
  );
endmodule

// File: tb/seg_xlate_test.sv
`timescale 1ns/1ps
module seg_xlate_test;
  localparam int NUM_SEG = 8;
  localparam int OFF_W   = 12;
  localparam int ADDR_W  = 16;
  localparam int SEG_W   = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 0, wrValid = 0, reqValid = 0;
  logic [SEG_W-1:0] wrSeg = '0, reqSeg = '0;
  logic [ADDR_W-1:0] wrBase = '0;
  logic [OFF_W:0] wrLimit = '0;
  logic [OFF_W-1:0] reqOff = '0;
  logic rspValid, rspFault;
  logic [ADDR_W-1:0] rspAddr;

  always #2.5 clk = ~clk;  // 200 MHz

  seg_xlate #(.NUM_SEG(NUM_SEG), .OFF_W(OFF_W), .ADDR_W(ADDR_W)) uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSeg(wrSeg), .wrBase(wrBase),
    .wrLimit(wrLimit), .wrValid(wrValid), .reqValid(reqValid),
    .reqSeg(reqSeg), .reqOff(reqOff),
    .rspValid(rspValid), .rspFault(rspFault), .rspAddr(rspAddr)
  );

  int errs = 0, checks = 0;
  int mBase[NUM_SEG], mLim[NUM_SEG];
  bit mVal[NUM_SEG];
  bit expV = 0, expF = 0, firstReq = 1, modelOn = 0;
  int expA = 0;
  string expTag = "R2";

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference model: decide response from table as it was, then apply write.
  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_SEG; i++) begin mBase[i] = 0; mLim[i] = 0; mVal[i] = 0; end
      expV = 0;
    end else begin
      expV = reqValid;
      if (reqValid) begin
        int s, o;
        s = int'(reqSeg); o = int'(reqOff);
        expF = 0; expA = 0;
        if (firstReq) expTag = "R1";
        else if (wrEn && wrSeg == reqSeg) expTag = "R8";
        else expTag = "R3,R4";
        if (!mVal[s]) begin expF = 1; if (!firstReq) expTag = "R6"; end
        else if (o >= mLim[s]) begin expF = 1; if (expTag != "R8") expTag = "R5"; end
        else if (mBase[s] + o >= (1 << ADDR_W)) begin expF = 1; if (expTag != "R8") expTag = "R7"; end
        else expA = mBase[s] + o;
        firstReq = 0;
      end
      if (wrEn) begin
        mBase[wrSeg] = int'(wrBase);
        mLim[wrSeg]  = int'(wrLimit);
        mVal[wrSeg]  = wrValid;
      end
    end
  end

  always @(negedge clk) begin
    if (modelOn) begin
      check(rspValid == expV, "R2", rspValid, expV);
      if (expV) begin
        check(rspFault == expF, expTag, rspFault, expF);
        if (expF) check(rspAddr == '0, "R9", rspAddr, 0);
        else      check(int'(rspAddr) == expA, expTag, rspAddr, expA);
      end
    end
  end

  task automatic drive(input bit we, input int ws, input int wb, input int wl, input bit wv,
                       input bit rv, input int rs, input int ro);
    @(negedge clk);
    wrEn = we; wrSeg = SEG_W'(ws); wrBase = ADDR_W'(wb); wrLimit = (OFF_W+1)'(wl); wrValid = wv;
    reqValid = rv; reqSeg = SEG_W'(rs); reqOff = OFF_W'(ro);
  endtask

  task automatic wr(input int s, input int b, input int l, input bit v);
    drive(1, s, b, l, v, 0, 0, 0);
  endtask

  task automatic rq(input int s, input int o);
    drive(0, 0, 0, 0, 0, 1, s, o);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check(rspValid == 1'b0, "R1", rspValid, 0);  // reset state
    modelOn = 1;
    rq(2, 5);                               // R1: nothing valid yet
    rq(0, 0);
    for (int i = 0; i < NUM_SEG; i++) wr(i, 16'h1000 * i + 16'h10 * i, 16'h100 + 16'h40 * i, 1);
    for (int i = 0; i < NUM_SEG; i++) rq(i, 16'h20 + i);         // R3, R4
    rq(3, 16'h100 + 16'h40 * 3 - 1);        // R4: last legal offset
    rq(3, 16'h100 + 16'h40 * 3);            // R5: offset equals limit
    rq(3, 16'hFFF);                         // R5: far beyond
    wr(7, 16'hFF00, 13'h1000, 1);
    rq(7, 16'h0FF);                         // R4: top address
    rq(7, 16'h100);                         // R7: overflow
    wr(5, 0, 0, 0);
    rq(5, 0);                               // R6: invalidated
    drive(1, 4, 16'h8000, 16'h20, 1, 1, 4, 16'h30);  // R8: old entry used
    rq(4, 16'h30);                          // R8: new limit now faults
    rq(4, 16'h1F);
    drive(0, 0, 0, 0, 0, 0, 0, 0);
    drive(0, 0, 0, 0, 0, 0, 0, 0);          // R2: idle gives no response
    for (int n = 0; n < 400; n++)
      drive($urandom_range(0, 3) == 0, $urandom_range(0, NUM_SEG - 1), $urandom,
            $urandom_range(0, 1 << OFF_W), $urandom_range(0, 5) != 0,
            $urandom_range(0, 3) != 0, $urandom_range(0, NUM_SEG - 1), $urandom);
    drive(0, 0, 0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule